// File: doc/BRIEF.md
# Manchester Transmit Encoder with Selectable Idle

The block turns a serial NRZ bit stream into Manchester code on a pair of complementary digital legs, a positive leg and a negative leg, for an external line driver. It runs from a clock at twice the bit rate, so each bit cell is two clock cycles long. One data bit is taken per bit cell, and a one-cycle request strobe marks the clock edge at which that bit is taken.

Encoding continues while the transmit-enable request is held high. The enable is looked at only at a bit-cell boundary, so a cell that has started always finishes both of its halves. When the request is low at a boundary, the legs enter an idle state. A mode-select input chooses the idle state:

- **Zero differential:** both legs sit at the same level, so a transformer-coupled load sees no DC.
- **Logical high:** the positive leg is held above the negative leg.

Top module: `mtx_encoder`

## Requirements
- R1: While reset is asserted, and with the enable low, both legs are at the zero-differential level (both 0 by default) and the request strobe is 0.
- R2: A bit taken at a request edge appears in the two cycles after that edge. A 0 gives a positive leg of 1 then 0, and a 1 gives 0 then 1.
- R3: During every cycle of an active cell, the negative leg is the complement of the positive leg.
- R4: The request strobe is high exactly in a cycle where the block is at a cell boundary and the enable is high. A boundary is any idle cycle or the second half of a cell. Under continuous enable the strobe therefore pulses on every other cycle.
- R5: Dropping the enable during the first half of a cell has no effect on that cell, which completes its second half before idle is entered.
- R6: In idle with the mode input low, the positive and negative legs are equal (both 0 by default).
- R7: In idle with the mode input high, the positive leg is 1 and the negative leg is 0.
- R8: The mode input has no effect on the legs while a cell is being encoded.
- R9: A change of the mode input while idle shows on the legs in the next cycle.
- R10: The data input has no effect except in a cycle where the request strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en_i | input | 1 | Transmit-enable request, sampled at cell boundaries |
| data_i | input | 1 | NRZ data bit, taken when bit_req_o is high |
| idle_hi_i | input | 1 | Idle select: 0 selects zero differential, 1 selects logical high |
| bit_req_o | output | 1 | One-cycle strobe: data_i is consumed at this clock edge |
| tx_p_o | output | 1 | Positive output leg |
| tx_n_o | output | 1 | Negative output leg |

## Verification
Directed bursts send a lone 0 and a lone 1, so the polarity of each half-cell is checked in both directions. An enable dropped in the first half of a cell shows whether the cell runs to completion or is cut short.

Toggling the mode input inside active cells checks that it is ignored there. Toggling it in idle checks that both idle states are produced and that each takes effect after a single cycle.

Random runs mix enable bursts of varied length with gaps, random data and random mode. Every leg value and every strobe is compared against a bench model. This catches strobe spacing errors, data taken in the wrong cycle and a wrong complement on the negative leg.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

    // State of the bit cell currently being sent.
    typedef struct packed {
        logic active;   // a cell is being encoded
        logic half;     // 0 = first half, 1 = second half
        logic bit_v;    // data bit of the current cell
    } mtx_cell_t;

    // Registered levels of the two output legs.
    typedef struct packed {
        logic pos;
        logic neg;
    } mtx_legs_t;

endpackage

// File: rtl/mtx_cell_timer.sv
module mtx_cell_timer
    import mtx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_i,
    input  logic data_i,
    output logic boundary_o,
    output logic start_o,
    output logic active_o,
    output logic half_o,
    output logic bit_o
);

    mtx_cell_t cell_d, cell_q;
    logic      boundary;

    // A boundary is any idle cycle or the second half of a cell.
    assign boundary = !cell_q.active || cell_q.half;

    always_comb begin
        cell_d = cell_q;
        if (boundary) begin
            cell_d.active = tx_en_i;
            cell_d.half   = 1'b0;
            if (tx_en_i) begin
                cell_d.bit_v = data_i;
            end
        end else begin
            cell_d.half = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign boundary_o = boundary;
    assign start_o    = boundary && tx_en_i;
    assign active_o   = cell_q.active;
    assign half_o     = cell_q.half;
    assign bit_o      = cell_q.bit_v;

endmodule

// File: rtl/mtx_leg_driver.sv
module mtx_leg_driver
    import mtx_pkg::*;
#(
    parameter logic ZERO_IDLE_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic boundary_i,
    input  logic start_i,
    input  logic data_i,
    input  logic cell_bit_i,
    input  logic idle_hi_i,
    output logic tx_p_o,
    output logic tx_n_o
);

    mtx_legs_t legs_d, legs_q;
    mtx_legs_t zero_idle;
    mtx_legs_t high_idle;

    generate
        if (ZERO_IDLE_LEVEL) begin : g_zero_hi
            assign zero_idle = '{pos: 1'b1, neg: 1'b1};
        end else begin : g_zero_lo
            assign zero_idle = '{pos: 1'b0, neg: 1'b0};
        end
    endgenerate

    assign high_idle = '{pos: 1'b1, neg: 1'b0};

    always_comb begin
        legs_d = legs_q;
        if (start_i) begin
            // first half: a 0 starts high, a 1 starts low
            legs_d.pos = !data_i;
            legs_d.neg = data_i;
        end else if (boundary_i) begin
            legs_d = idle_hi_i ? high_idle : zero_idle;
        end else begin
            // second half: level equals the data bit
            legs_d.pos = cell_bit_i;
            legs_d.neg = !cell_bit_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            legs_q <= zero_idle;
        end else begin
            legs_q <= legs_d;
        end
    end

    assign tx_p_o = legs_q.pos;
    assign tx_n_o = legs_q.neg;

endmodule

// File: rtl/mtx_encoder.sv
module mtx_encoder
    import mtx_pkg::*;
#(
    parameter logic ZERO_IDLE_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_i,
    input  logic data_i,
    input  logic idle_hi_i,
    output logic bit_req_o,
    output logic tx_p_o,
    output logic tx_n_o
);

    logic cell_boundary;
    logic cell_start;
    logic cell_active;
    logic cell_half;
    logic cell_bit;

    mtx_cell_timer u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en_i    (tx_en_i),
        .data_i     (data_i),
        .boundary_o (cell_boundary),
        .start_o    (cell_start),
        .active_o   (cell_active),
        .half_o     (cell_half),
        .bit_o      (cell_bit)
    );

    mtx_leg_driver #(
        .ZERO_IDLE_LEVEL (ZERO_IDLE_LEVEL)
    ) u_legs (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary_i (cell_boundary),
        .start_i    (cell_start),
        .data_i     (data_i),
        .cell_bit_i (cell_bit),
        .idle_hi_i  (idle_hi_i),
        .tx_p_o     (tx_p_o),
        .tx_n_o     (tx_n_o)
    );

    assign bit_req_o = cell_start;

endmodule

// File: rtl/mtx_encoder_checker.sv
module mtx_encoder_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en_i,
    input logic data_i,
    input logic idle_hi_i,
    input logic bit_req_o,
    input logic tx_p_o,
    input logic tx_n_o,
    input logic active,
    input logic half
);

    // R2: first half carries the inverse of the bit taken at the request
    p_first_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_req_o |=> (tx_p_o == !$past(data_i)));

    // R2: mid-cell transition on the positive leg
    p_mid_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !half) |=> (tx_p_o == !$past(tx_p_o)));

    // R3: legs complementary while encoding
    p_legs_comp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_req_o |=> (tx_n_o == !tx_p_o));

    // R4: no two strobes in a row
    p_req_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_req_o |=> !bit_req_o);

    // R5: a first half is always followed by a second half
    p_cell_completes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !half) |=> (active && half));

    // R6: zero-differential idle
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((!active || half) && !tx_en_i && !idle_hi_i) |=> (tx_p_o == tx_n_o));

    // R7: logical-high idle
    p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((!active || half) && !tx_en_i && idle_hi_i) |=> (tx_p_o && !tx_n_o));

endmodule

bind mtx_encoder mtx_encoder_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en_i   (tx_en_i),
    .data_i    (data_i),
    .idle_hi_i (idle_hi_i),
    .bit_req_o (bit_req_o),
    .tx_p_o    (tx_p_o),
    .tx_n_o    (tx_n_o),
    .active    (cell_active),
    .half      (cell_half)
);

// File: tb/test_mtx_encoder.sv
module test_mtx_encoder;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic tx_en;
    logic data;
    logic idle_hi;
    logic bit_req;
    logic tx_p;
    logic tx_n;

    int n_checks = 0;
    int n_fails  = 0;

    // bench reference model
    logic m_act, m_half, m_bit, m_p, m_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mtx_encoder i_mtx_encoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en_i   (tx_en),
        .data_i    (data),
        .idle_hi_i (idle_hi),
        .bit_req_o (bit_req),
        .tx_p_o    (tx_p),
        .tx_n_o    (tx_n)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_req(input logic en);
        return (!m_act || m_half) && en;
    endfunction

    task automatic model_update(input logic en, input logic d, input logic mode);
        if (!m_act || m_half) begin
            m_half = 1'b0;
            m_act  = en;
            if (en) begin
                m_bit = d;
                m_p   = !d;
                m_n   = d;
            end else begin
                m_p = mode;
                m_n = 1'b0;
            end
        end else begin
            m_half = 1'b1;
            m_p    = m_bit;
            m_n    = !m_bit;
        end
    endtask

    // Called at a negedge: drive, check strobe, clock, check legs.
    task automatic step(input logic en, input logic d, input logic mode);
        tx_en   = en;
        data    = d;
        idle_hi = mode;
        #1;
        chk("R4 bit_req", bit_req, exp_req(en));
        @(posedge clk);
        model_update(en, d, mode);
        @(negedge clk);
        if (m_act) begin
            chk("R2 tx_p", tx_p, m_p);
            chk("R3 tx_n", tx_n, m_n);
        end else if (m_p) begin
            chk("R7 idle tx_p", tx_p, m_p);
            chk("R7 idle tx_n", tx_n, m_n);
        end else begin
            chk("R6 idle tx_p", tx_p, m_p);
            chk("R6 idle tx_n", tx_n, m_n);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n   = 1'b0;
        tx_en   = 1'b0;
        data    = 1'b0;
        idle_hi = 1'b0;
        m_act = 0; m_half = 0; m_bit = 0; m_p = 0; m_n = 0;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk("R1 tx_p", tx_p, 1'b0);
        chk("R1 tx_n", tx_n, 1'b0);
        chk("R1 bit_req", bit_req, 1'b0);
        rst_n = 1'b1;
        step(0, 0, 0);

        // R2: lone 0 -> positive leg 1 then 0
        step(1, 0, 0);
        chk("R2 zero first half", tx_p, 1'b1);
        step(0, 1, 0);
        chk("R2 zero second half", tx_p, 1'b0);
        step(0, 0, 0);
        chk("R6 zero idle equal legs", tx_p ^ tx_n, 1'b0);

        // R2: lone 1 -> positive leg 0 then 1
        step(1, 1, 0);
        chk("R2 one first half", tx_p, 1'b0);
        step(0, 0, 0);
        chk("R2 one second half", tx_p, 1'b1);

        // R5: enable dropped in first half, cell still completes
        step(1, 1, 0);
        step(0, 0, 0);
        chk("R5 second half kept", tx_p, 1'b1);
        chk("R5 second half neg", tx_n, 1'b0);

        // R7, R9: idle high, then back to zero idle next cycle
        step(0, 0, 1);
        chk("R9 idle high next cycle", tx_p, 1'b1);
        chk("R7 idle high neg", tx_n, 1'b0);
        step(0, 0, 0);
        chk("R9 idle zero next cycle", tx_p, 1'b0);

        // R8: mode toggled while a cell runs; R10: data changed mid-cell
        step(1, 0, 1);
        chk("R8 first half ignores mode", tx_p, 1'b1);
        step(1, 1, 0);   // strobe: new bit 1 taken here? no, this is 2nd half
        chk("R10 second half ignores data", tx_p, 1'b0);
        chk("R8 second half ignores mode", tx_n, 1'b1);
        step(0, 1, 1);
        chk("R7 idle after burst", tx_p, 1'b1);

        // random mix of bursts, gaps, data and mode
        for (int burst = 0; burst < 300; burst++) begin
            int len;
            logic en_now;
            len    = 1 + int'($urandom_range(0, 9));
            en_now = logic'($urandom_range(0, 2) != 0);
            for (int k = 0; k < len; k++) begin
                step(en_now, logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)));
            end
        end

        finish_run();
    end

endmodule